// File: doc/BRIEF.md
# Soft-Off Wake Event Aggregator

This block watches every source that may bring a host out of the soft-off power state and raises one wake request when a qualifying event has been recorded. It takes a power button, four general-purpose inputs from the always-on supply domain, an active-low PCIe-style WAKE# pin, an internal LAN wake line, one wake line per USB controller, an aggregated power-management-event line, an RTC alarm and a firmware wake request. Each source owns a sticky status bit. The bit is set on a rising edge of its source and is cleared by a write-one-to-clear strobe.

Whether a recorded event may wake the host depends on the enable and disable settings and on how soft-off was entered. The block keeps a flag that tells whether entry was through the software sleep-enable path or through a power failure or reset. Sources that only work after software entry are masked after the other kind of entry. The power button and the firmware request are never masked. A LAN event is also allowed after a power-failure entry when the wake-on-LAN override is set. The power-up sequencing that follows the request, and the register bus, belong to other blocks.

Top module: `softoff_wake_agg`

## Requirements
- R1: A falling edge on the active-low power button pin sets status bit 0. This bit requests a wake in either entry mode, with no enable.
- R2: A rising edge on general-purpose input i (i = 0..3) sets status bit 1+i. That bit requests a wake only when enable bit i is set and entry was through software.
- R3: A falling edge on the active-low PCIe wake pin sets status bit 5. That bit requests a wake only when the PCIe-wake disable bit is clear and entry was through software.
- R4: A rising edge on the internal LAN wake line sets status bit 6. That bit requests a wake after software entry, and also after any entry when the wake-on-LAN override bit is set.
- R5: A rising edge on USB controller wake line j (j = 0..1) sets status bit 7+j. That bit requests a wake only when USB enable bit j is set and entry was through software.
- R6: A rising edge on the power-management-event line sets status bit 9. That bit requests a wake when its enable is set and entry was through software. A bit that is already set when software entry happens raises the request in the cycle after the entry strobe.
- R7: A rising edge on the RTC alarm sets status bit 10. That bit requests a wake only after software entry.
- R8: A rising edge on the firmware wake line sets status bit 11. That bit always requests a wake, and it is also presented on its own firmware-wake status output.
- R9: Status bits are sticky. Only a 1 in the matching bit of the clear strobe clears a bit. A source held high after a clear does not set the bit again until it has fallen and then risen once more.
- R10: When a rising edge and a clear strobe hit the same status bit in the same cycle, the bit ends up set.
- R11: External pins pass through a two-flop synchronizer, so their status bit is set at the third rising clock edge after the pin changes. Internal lines set their status bit at the first edge.
- R12: The entry flag is 0 after reset, which means power-failure entry. The software entry strobe sets it. The power-failure/reset entry strobe clears it, and this strobe wins when both strobes arrive in the same cycle.
- R13: The wake request is the OR of all status bits, each ANDed with its qualifying condition. It stays high while any qualifying bit remains set and falls once those bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwrbtn_ni | input | 1 | Power button pin, active low |
| gpio_i | input | NUM_GPIO | Always-on general-purpose wake pins |
| pcie_wake_ni | input | 1 | PCIe-style WAKE# pin, active low |
| lan_wake_i | input | 1 | Internal LAN wake line |
| usb_wake_i | input | NUM_USB | Per-controller USB wake lines |
| pme_i | input | 1 | Aggregated power-management-event line |
| rtc_alarm_i | input | 1 | RTC alarm line |
| fw_wake_i | input | 1 | Firmware-initiated wake request |
| sw_entry_i | input | 1 | One-cycle strobe: soft-off entered through software |
| hw_entry_i | input | 1 | One-cycle strobe: soft-off entered through power failure or reset |
| gpio_en_i | input | NUM_GPIO | Per-input wake enables |
| usb_en_i | input | NUM_USB | Per-controller USB wake enables |
| pme_en_i | input | 1 | Power-management-event wake enable |
| pcie_dis_i | input | 1 | PCIe wake disable |
| wol_ovr_i | input | 1 | Wake-on-LAN override for power-failure entry |
| sts_clr_i | input | NUM_GPIO+NUM_USB+6 | Write-one-to-clear strobes, one per status bit |
| sts_o | output | NUM_GPIO+NUM_USB+6 | Sticky status bits |
| fw_wake_sts_o | output | 1 | Firmware-caused-wake status |
| sw_entered_o | output | 1 | Entry flag, 1 for software entry |
| wake_req_o | output | 1 | Wake request |

## Verification
A rising edge on a source and the software clear of the same status bit can arrive in the same cycle. The bench provokes this by raising the internal LAN line in the very cycle that a clear strobe for bit 6 is driven. The bit must read as set afterwards, so the event is not lost. The two entry strobes can also coincide. The bench pulses both together and expects the flag to show power-failure entry, which it judges at the ports through the flag output and through a general-purpose event that must then stay masked.

// File: rtl/wake_agg_pkg.sv
package wake_agg_pkg;

  typedef enum logic {
    ENTRY_POWERFAIL = 1'b0,
    ENTRY_SOFTWARE  = 1'b1
  } entry_mode_e;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/wake_edge.sv
module wake_edge #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= level_i;
    end
  end

  assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/wake_sts_bank.sv
module wake_sts_bank #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] sts_o
);

  logic [WIDTH-1:0] sts_q;
  logic [WIDTH-1:0] sts_d;
  logic             sts_en;

  always_comb begin
    sts_en = (|set_i) | (|(clr_i & sts_q));
    sts_d  = (sts_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  assign sts_o = sts_q;

  AST_STS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sts_q) & ~$past(clr_i)) & ~sts_q) == '0)); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~sts_q) == '0)); // R10

endmodule

// File: rtl/wake_qualify.sv
module wake_qualify #(
  parameter int unsigned NUM_GPIO = 4,
  parameter int unsigned NUM_USB  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_GPIO+NUM_USB+5:0]  sts_i,
  input  logic [NUM_GPIO-1:0]          gpio_en_i,
  input  logic [NUM_USB-1:0]           usb_en_i,
  input  logic                         pme_en_i,
  input  logic                         pcie_dis_i,
  input  logic                         wol_ovr_i,
  input  wake_agg_pkg::entry_mode_e    mode_i,
  output logic                         wake_req_o
);

  localparam int unsigned NSRC     = NUM_GPIO + NUM_USB + 6;
  localparam int unsigned IDX_PWR  = 0;
  localparam int unsigned IDX_GPIO = 1;
  localparam int unsigned IDX_PCIE = NUM_GPIO + 1;
  localparam int unsigned IDX_LAN  = NUM_GPIO + 2;
  localparam int unsigned IDX_USB  = NUM_GPIO + 3;
  localparam int unsigned IDX_PME  = NUM_GPIO + NUM_USB + 3;
  localparam int unsigned IDX_RTC  = NUM_GPIO + NUM_USB + 4;
  localparam int unsigned IDX_FW   = NUM_GPIO + NUM_USB + 5;

  logic            sw_mode;
  logic [NSRC-1:0] qual;

  assign sw_mode = (mode_i == wake_agg_pkg::ENTRY_SOFTWARE);

  assign qual[IDX_PWR] = 1'b1;

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio_qual
    assign qual[IDX_GPIO+g] = gpio_en_i[g] & sw_mode;
  end

  assign qual[IDX_PCIE] = ~pcie_dis_i & sw_mode;
  assign qual[IDX_LAN]  = sw_mode | wol_ovr_i;

  for (genvar u = 0; u < NUM_USB; u++) begin : g_usb_qual
    assign qual[IDX_USB+u] = usb_en_i[u] & sw_mode;
  end

  assign qual[IDX_PME] = pme_en_i & sw_mode;
  assign qual[IDX_RTC] = sw_mode;
  assign qual[IDX_FW]  = 1'b1;

  assign wake_req_o = |(sts_i & qual);

  AST_PWRBTN_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_i[IDX_PWR] |-> wake_req_o); // R1
  AST_FW_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_i[IDX_FW] |-> wake_req_o); // R8
  AST_POWERFAIL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_mode && !wol_ovr_i) |-> (wake_req_o == (sts_i[IDX_PWR] | sts_i[IDX_FW]))); // R7
  AST_WAKE_NEEDS_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> (|sts_i)); // R13

endmodule

// File: rtl/softoff_wake_agg.sv
module softoff_wake_agg #(
  parameter int unsigned NUM_GPIO    = 4,
  parameter int unsigned NUM_USB     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        pwrbtn_ni,
  input  logic [NUM_GPIO-1:0]         gpio_i,
  input  logic                        pcie_wake_ni,
  input  logic                        lan_wake_i,
  input  logic [NUM_USB-1:0]          usb_wake_i,
  input  logic                        pme_i,
  input  logic                        rtc_alarm_i,
  input  logic                        fw_wake_i,
  input  logic                        sw_entry_i,
  input  logic                        hw_entry_i,
  input  logic [NUM_GPIO-1:0]         gpio_en_i,
  input  logic [NUM_USB-1:0]          usb_en_i,
  input  logic                        pme_en_i,
  input  logic                        pcie_dis_i,
  input  logic                        wol_ovr_i,
  input  logic [NUM_GPIO+NUM_USB+5:0] sts_clr_i,
  output logic [NUM_GPIO+NUM_USB+5:0] sts_o,
  output logic                        fw_wake_sts_o,
  output logic                        sw_entered_o,
  output logic                        wake_req_o
);

  import wake_agg_pkg::*;

  localparam int unsigned NSRC   = NUM_GPIO + NUM_USB + 6;
  localparam int unsigned NPIN   = NUM_GPIO + 2;
  localparam int unsigned NINT   = NUM_USB + 4;
  localparam int unsigned IDX_FW = NSRC - 1;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n = rst_pipe_q[1];

  // Pins, normalised to active high: power button, GPIOs, PCIe wake
  logic [NPIN-1:0] pin_raw;
  logic [NPIN-1:0] pin_sync;
  logic [NINT-1:0] int_raw;
  logic [NSRC-1:0] level_all;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] sts;

  assign pin_raw = {~pcie_wake_ni, gpio_i, ~pwrbtn_ni};
  assign int_raw = {fw_wake_i, rtc_alarm_i, pme_i, usb_wake_i, lan_wake_i};

  wake_sync #(
    .WIDTH  (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_pin_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .async_i (pin_raw),
    .sync_o  (pin_sync)
  );

  assign level_all = {int_raw, pin_sync};

  wake_edge #(
    .WIDTH (NSRC)
  ) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .level_i (level_all),
    .rise_o  (set_vec)
  );

  wake_sts_bank #(
    .WIDTH (NSRC)
  ) u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (set_vec),
    .clr_i  (sts_clr_i),
    .sts_o  (sts)
  );

  // Entry-mode flag
  entry_mode_e mode_q;
  entry_mode_e mode_d;
  logic        mode_en;

  always_comb begin
    mode_en = sw_entry_i | hw_entry_i;
    mode_d  = hw_entry_i ? ENTRY_POWERFAIL : ENTRY_SOFTWARE;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ENTRY_POWERFAIL;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  wake_qualify #(
    .NUM_GPIO (NUM_GPIO),
    .NUM_USB  (NUM_USB)
  ) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sts_i      (sts),
    .gpio_en_i  (gpio_en_i),
    .usb_en_i   (usb_en_i),
    .pme_en_i   (pme_en_i),
    .pcie_dis_i (pcie_dis_i),
    .wol_ovr_i  (wol_ovr_i),
    .mode_i     (mode_q),
    .wake_req_o (wake_req_o)
  );

  assign sts_o         = sts;
  assign fw_wake_sts_o = sts[IDX_FW];
  assign sw_entered_o  = (mode_q == ENTRY_SOFTWARE);

  AST_ENTRY_SW_SETS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sw_entry_i && !hw_entry_i) |=> sw_entered_o); // R12
  AST_ENTRY_HW_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    hw_entry_i |=> !sw_entered_o); // R12
  AST_ENTRY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!sw_entry_i && !hw_entry_i) |=> $stable(sw_entered_o)); // R12

endmodule

// File: tb/softoff_wake_agg_tb_top.sv
`timescale 1ns/1ps
module softoff_wake_agg_tb_top;

  localparam int NSRC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrbtn_n = 1'b1;
  logic [3:0] gpio = '0;
  logic pcie_n = 1'b1;
  logic lan = 1'b0;
  logic [1:0] usb = '0;
  logic pme = 1'b0;
  logic rtc = 1'b0;
  logic fw = 1'b0;
  logic sw_entry = 1'b0;
  logic hw_entry = 1'b0;
  logic [3:0] gpio_en = '0;
  logic [1:0] usb_en = '0;
  logic pme_en = 1'b0;
  logic pcie_dis = 1'b0;
  logic wol = 1'b0;
  logic [NSRC-1:0] clr = '0;
  logic [NSRC-1:0] sts;
  logic fw_sts;
  logic sw_entered;
  logic wake;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  softoff_wake_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwrbtn_ni(pwrbtn_n), .gpio_i(gpio),
    .pcie_wake_ni(pcie_n), .lan_wake_i(lan), .usb_wake_i(usb), .pme_i(pme),
    .rtc_alarm_i(rtc), .fw_wake_i(fw), .sw_entry_i(sw_entry), .hw_entry_i(hw_entry),
    .gpio_en_i(gpio_en), .usb_en_i(usb_en), .pme_en_i(pme_en), .pcie_dis_i(pcie_dis),
    .wol_ovr_i(wol), .sts_clr_i(clr), .sts_o(sts), .fw_wake_sts_o(fw_sts),
    .sw_entered_o(sw_entered), .wake_req_o(wake)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(int k, logic v);
    case (k)
      0:       pwrbtn_n = ~v;
      1,2,3,4: gpio[k-1] = v;
      5:       pcie_n = ~v;
      6:       lan = v;
      7,8:     usb[k-7] = v;
      9:       pme = v;
      10:      rtc = v;
      default: fw = v;
    endcase
  endtask

  task automatic pulse_clr(logic [NSRC-1:0] m);
    clr = m;
    cyc(1);
    clr = '0;
  endtask

  task automatic enter(logic software);
    if (software) sw_entry = 1'b1; else hw_entry = 1'b1;
    cyc(1);
    sw_entry = 1'b0;
    hw_entry = 1'b0;
  endtask

  function automatic string tag(int k);
    case (k)
      0:       return "R1";
      1,2,3,4: return "R2";
      5:       return "R3";
      6:       return "R4";
      7,8:     return "R5";
      9:       return "R6";
      10:      return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic expect_wake(int k, logic sw, logic en, logic w);
    case (k)
      0, 11: return 1'b1;
      6:     return sw | w;
      10:    return sw;
      default: return sw & en;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    check("R9 reset status", 32'(sts), 32'h0);
    check("R13 reset wake", 32'(wake), 32'h0);
    check("R12 reset entry flag", 32'(sw_entered), 32'h0);

    // Sweep: every source x entry mode x enable x override
    for (int k = 0; k < NSRC; k++) begin
      for (int c = 0; c < 8; c++) begin
        logic sw, en, w;
        sw = c[0]; en = c[1]; w = c[2];
        gpio_en = {4{en}}; usb_en = {2{en}}; pme_en = en;
        pcie_dis = ~en; wol = w;
        enter(sw);
        pulse_clr('1);
        set_src(k, 1'b1);
        cyc(4);
        check({tag(k), " status set"}, 32'(sts), 32'(1) << k);
        check({tag(k), " wake qualify"}, 32'(wake), 32'(expect_wake(k, sw, en, w)));
        if (k == 11) check("R8 fw status out", 32'(fw_sts), 32'h1);
        set_src(k, 1'b0);
        cyc(4);
        check("R9 sticky after source drop", 32'(sts), 32'(1) << k);
        pulse_clr(NSRC'(1) << k);
        check("R9 w1c clears", 32'(sts), 32'h0);
        check("R13 wake falls", 32'(wake), 32'h0);
      end
    end

    // R11 latency: pin three edges, internal line one edge
    gpio_en = '1; usb_en = '1; pme_en = 1'b1; pcie_dis = 1'b0; wol = 1'b0;
    enter(1'b1);
    gpio[0] = 1'b1;
    cyc(2);
    check("R11 pin not yet set after two edges", 32'(sts[1]), 32'h0);
    cyc(1);
    check("R11 pin set at third edge", 32'(sts[1]), 32'h1);
    lan = 1'b1;
    cyc(1);
    check("R11 internal set at first edge", 32'(sts[6]), 32'h1);

    // R9 held level does not re-set
    pulse_clr(NSRC'(1) << 1);
    cyc(4);
    check("R9 held pin no re-set", 32'(sts[1]), 32'h0);
    gpio[0] = 1'b0;

    // R10 set and clear in same cycle
    lan = 1'b0;
    cyc(2);
    lan = 1'b1;
    clr = NSRC'(1) << 6;
    cyc(1);
    clr = '0;
    check("R10 set wins over clear", 32'(sts[6]), 32'h1);
    lan = 1'b0;
    cyc(2);
    pulse_clr('1);

    // R6 status recorded before software entry
    enter(1'b0);
    pme = 1'b1;
    cyc(1);
    pme = 1'b0;
    check("R6 pme recorded", 32'(sts[9]), 32'h1);
    check("R6 pme masked on powerfail entry", 32'(wake), 32'h0);
    enter(1'b1);
    check("R6 pre-set pme wakes on entry", 32'(wake), 32'h1);
    pulse_clr('1);

    // R12 both strobes together: powerfail wins
    sw_entry = 1'b1; hw_entry = 1'b1;
    cyc(1);
    sw_entry = 1'b0; hw_entry = 1'b0;
    check("R12 powerfail strobe wins", 32'(sw_entered), 32'h0);
    gpio[2] = 1'b1;
    cyc(4);
    check("R12 gpio masked after tie", 32'(wake), 32'h0);
    enter(1'b1);
    check("R12 software strobe sets flag", 32'(sw_entered), 32'h1);
    check("R2 gpio now qualifies", 32'(wake), 32'h1);
    gpio[2] = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule